// File: doc/BRIEF.md
# Fixed-Point Reciprocal and Inverse Square Root Lane Unit

This unit produces a fixed-point reciprocal or reciprocal square root for one lane of an eight-lane, 16-bit vector datapath. A source lane is picked from the incoming 128-bit vector and turned into a 32-bit signed operand. Its magnitude is normalised by a leading-zero count, and nine bits below the leading one address a 512-entry seed table. The table value, with an implicit leading one, is then shifted back to the operand's scale and sign-corrected. Both seed tables are computed at elaboration by constant functions, so no memory content is written out anywhere.

Precision can be widened to a 32-bit operand with a two-instruction sequence. A "high" operation latches the selected lane as the upper half of the next operand, marks a wide operation as pending, and returns the upper 16 bits kept from the last computed result. A following "low" operation joins the latched half with its own lane. Any other non-high operation uses the lane sign-extended to 32 bits. The path from operand to result is combinational. The pending flag, the latched half and the stored upper result change only on a cycle where the valid strobe is high.

Top module: `rcp_unit`

## Requirements
- R1: After reset the pending flag and the stored upper result are zero: a high operation issued first returns 0x0000, and a low operation issued first uses the sign-extended lane.
- R2: Lanes are numbered so that lane k occupies srcVec bits 16k+15 down to 16k. The source lane is 7 − srcSel. dstLane equals 7 − dstSel, and dstValid follows opValid in the same cycle.
- R3: opCode bit 2 selects the square-root variant (0 = reciprocal, 1 = inverse square root). Bits 1:0 select the precision form: 00 single, 01 low, 10 high, and 11 acts as single. The operand is {latched half, lane} only for a low form while the flag is pending. In every other case it is the lane sign-extended.
- R4: An operand of zero yields the 32-bit result 0x7FFFFFFF. An operand equal to 0xFFFF8000 yields 0xFFFF0000.
- R5: Reciprocal, general case. Let s be the leading-zero count of the magnitude and T the table value at bits 30:22 of the magnitude shifted left by s. The result is ((0x10000 | T) << 14) >> (31 − s), XORed with the sign mask. Table entry 0 is 0xFFFF; entry i ≥ 1 is the low 16 bits of (floor(2^34/(i+512)) + 1) >> 8.
- R6: Inverse square root, general case. The table is addressed with {index bits 8:1, s bit 0}, and the result is ((0x10000 | S) << 14) >> ((31 − s) / 2), XORed with the sign mask. S at entry i is the low 16 bits of b >> 1, where b ≥ 2^17 is the smallest value with a·(b+1)² ≥ 2^44, and a is i+512, halved when i is odd.
- R7: The sign mask is the operand shifted arithmetically right by 31. The magnitude is the operand XOR the mask, plus one only when the operand is above −32768, so more negative wide operands take a one's-complement magnitude. Outside the R4 cases, the result's sign bit equals the operand's sign bit.
- R8: A valid non-high operation clears the pending flag, stores result bits 31:16, and returns result bits 15:0 on dstData.
- R9: A valid high operation sets the pending flag, latches the source lane, returns the stored upper result on dstData, and leaves the stored upper result unchanged.
- R10: A cycle with opValid low changes none of the pending flag, the latched half or the stored upper result, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| opValid | input | 1 | Operation strobe for this cycle |
| opCode | input | 3 | Bit 2 variant, bits 1:0 precision form |
| srcVec | input | 128 | Eight 16-bit source lanes |
| srcSel | input | 3 | Source element field |
| dstSel | input | 3 | Destination element field |
| dstValid | output | 1 | Result lane is valid |
| dstLane | output | 3 | Destination lane number |
| dstData | output | 16 | Destination lane value |

## Verification
Assertions are evaluated on every cycle. They check the two saturating operand cases and that the result's sign follows the operand's sign. They also check how the control state moves: the pending flag is set or cleared by each operation form, a high operation latches its lane and keeps the stored half, and idle cycles change nothing. The numeric values, including table contents, rounding of the normalise and denormalise shifts, the one's-complement magnitude of very negative wide operands, and high/low pairing across idle gaps, can only be shown by the bench. It compares every output against a behavioural model that builds its own tables from the formulas.

// File: rtl/rcp_pkg.sv
package rcp_pkg;
  localparam int LANES     = 8;
  localparam int LANE_W    = 16;
  localparam int SEL_W     = $clog2(LANES);
  localparam int VEC_W     = LANES * LANE_W;
  localparam int RES_W     = 2 * LANE_W;
  localparam int IDX_W     = 9;
  localparam int TBL_DEPTH = 1 << IDX_W;

  localparam logic [1:0] FORM_LOW  = 2'b01;
  localparam logic [1:0] FORM_HIGH = 2'b10;

  typedef struct packed {
    logic wideOperand;
    logic sqrtMode;
  } ctrlStrobe_t;

  function automatic logic [LANE_W-1:0] rcpEntry(int i);
    longint q;
    if (i == 0) return 16'hFFFF;
    q = (longint'(1) << 34) / longint'(i + TBL_DEPTH);
    return LANE_W'((q + 1) >> 8);
  endfunction

  function automatic logic [LANE_W-1:0] rsqEntry(int i);
    longint a, lo, hi, mid;
    a  = longint'(i + TBL_DEPTH);
    if ((i % 2) == 1) a = a >> 1;
    lo = longint'(1) << 17;
    hi = longint'(1) << 19;
    while (lo < hi) begin
      mid = (lo + hi) >> 1;
      if (a * (mid + 1) * (mid + 1) >= (longint'(1) << 44)) hi = mid;
      else lo = mid + 1;
    end
    return LANE_W'(lo >> 1);
  endfunction
endpackage

// File: rtl/rcp_datapath.sv
module rcp_datapath
  import rcp_pkg::*;
(
  input  ctrlStrobe_t       strobe,
  input  logic [LANE_W-1:0] highIn,
  input  logic [LANE_W-1:0] srcLane,
  output logic [RES_W-1:0]  result
);
  logic [LANE_W-1:0] rcpTbl [TBL_DEPTH];
  logic [LANE_W-1:0] rsqTbl [TBL_DEPTH];

  for (genvar g = 0; g < TBL_DEPTH; g++) begin : g_tbl
    localparam logic [LANE_W-1:0] RCP_V = rcpEntry(g);
    localparam logic [LANE_W-1:0] RSQ_V = rsqEntry(g);
    assign rcpTbl[g] = RCP_V;
    assign rsqTbl[g] = RSQ_V;
  end

  logic [RES_W-1:0] operand, mask, mag, norm, rcpBase, rsqBase;
  logic [4:0]       msb, shiftAmt;
  logic [IDX_W-1:0] idx, rsqIdx;

  always_comb begin
    operand = strobe.wideOperand ? {highIn, srcLane}
                                 : {{LANE_W{srcLane[LANE_W-1]}}, srcLane};
    mask = {RES_W{operand[RES_W-1]}};
    mag  = operand ^ mask;
    if ($signed(operand) > -32'sd32768) mag = mag - mask;
    msb = '0;
    for (int k = 0; k < RES_W; k++) begin
      if (mag[k]) msb = 5'(k);
    end
    shiftAmt = 5'd31 - msb;
    norm     = mag << shiftAmt;
    idx      = norm[30:22];
    rsqIdx   = {idx[IDX_W-1:1], shiftAmt[0]};
    rcpBase  = {15'd0, 1'b1, rcpTbl[idx]} << 14;
    rsqBase  = {15'd0, 1'b1, rsqTbl[rsqIdx]} << 14;
    if (mag == '0)                  result = 32'h7FFF_FFFF;
    else if (operand == 32'hFFFF_8000) result = 32'hFFFF_0000;
    else if (strobe.sqrtMode)       result = (rsqBase >> msb[4:1]) ^ mask;
    else                            result = (rcpBase >> msb) ^ mask;
  end

  always_comb begin
    // R4
    if (operand == '0) zero_sat_chk: assert (result == 32'h7FFF_FFFF);
    // R4
    if (operand == 32'hFFFF_8000) neg_limit_chk: assert (result == 32'hFFFF_0000);
    // R7
    if (operand != '0 && operand != 32'hFFFF_8000)
      sign_follow_chk: assert (result[RES_W-1] == operand[RES_W-1]);
  end
endmodule

// File: rtl/rcp_ctrl.sv
module rcp_ctrl
  import rcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [LANE_W-1:0] srcLane,
  input  logic [RES_W-1:0]  result,
  output ctrlStrobe_t       strobe,
  output logic [LANE_W-1:0] highIn,
  output logic [LANE_W-1:0] dstData
);
  logic              highPend;
  logic [LANE_W-1:0] resHi;
  logic              isHigh, isLow;

  assign isHigh = (opCode[1:0] == FORM_HIGH);
  assign isLow  = (opCode[1:0] == FORM_LOW);
  assign strobe.wideOperand = highPend && isLow;
  assign strobe.sqrtMode    = opCode[2];
  assign dstData = isHigh ? resHi : result[LANE_W-1:0];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      highPend <= 1'b0;
      highIn   <= '0;
      resHi    <= '0;
    end else if (opValid) begin
      if (isHigh) begin
        highPend <= 1'b1;
        highIn   <= srcLane;
      end else begin
        highPend <= 1'b0;
        resHi    <= result[RES_W-1:LANE_W];
      end
    end
  end

  // R9
  high_latch_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && isHigh |=> highPend && highIn == $past(srcLane) && $stable(resHi));
  // R8
  low_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    opValid && !isHigh |=> !highPend && resHi == $past(result[RES_W-1:LANE_W]));
  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !opValid |=> $stable(highPend) && $stable(highIn) && $stable(resHi));
endmodule

// File: rtl/rcp_unit.sv
module rcp_unit
  import rcp_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              opValid,
  input  logic [2:0]        opCode,
  input  logic [VEC_W-1:0]  srcVec,
  input  logic [SEL_W-1:0]  srcSel,
  input  logic [SEL_W-1:0]  dstSel,
  output logic              dstValid,
  output logic [SEL_W-1:0]  dstLane,
  output logic [LANE_W-1:0] dstData
);
  logic [LANE_W-1:0] lanes [LANES];
  logic [LANE_W-1:0] srcLane, highIn;
  logic [RES_W-1:0]  result;
  ctrlStrobe_t       strobe;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lanes[g] = srcVec[g*LANE_W +: LANE_W];
  end

  assign srcLane  = lanes[SEL_W'(LANES - 1) - srcSel];
  assign dstLane  = SEL_W'(LANES - 1) - dstSel;
  assign dstValid = opValid;

  rcp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcLane(srcLane), .result(result), .strobe(strobe),
    .highIn(highIn), .dstData(dstData)
  );

  rcp_datapath u_dp (
    .strobe(strobe), .highIn(highIn), .srcLane(srcLane), .result(result)
  );
endmodule

// File: tb/rcp_unit_tb.sv
module rcp_unit_tb;
  logic         clk = 1'b0, rstN = 1'b0, opValid = 1'b0;
  logic [2:0]   opCode = '0, srcSel = '0, dstSel = '0;
  logic [127:0] srcVec = '0;
  logic         dstValid;
  logic [2:0]   dstLane;
  logic [15:0]  dstData;

  rcp_unit u_dut (.clk(clk), .rstN(rstN), .opValid(opValid), .opCode(opCode),
    .srcVec(srcVec), .srcSel(srcSel), .dstSel(dstSel),
    .dstValid(dstValid), .dstLane(dstLane), .dstData(dstData));

  always #5 clk = ~clk;

  int checks = 0, errors = 0;
  longint rTbl [512];
  longint sTbl [512];
  bit          mPend;
  logic [15:0] mLatch, mResHi;

  task automatic check(string req, longint act, longint exp, string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] refCalc(logic [31:0] opnd, bit sq);
    longint x, mag, v;
    int p, idx;
    x = longint'($signed(opnd));
    if (x == 0) return 32'h7FFFFFFF;
    if (opnd == 32'hFFFF8000) return 32'hFFFF0000;
    if (x < 0) mag = (x > -32768) ? -x : -x - 1;
    else mag = x;
    p = 0;
    for (int k = 0; k < 32; k++) if (((mag >> k) & 1) == 1) p = k;
    idx = int'(((mag << (31 - p)) >> 22) & 511);
    if (!sq) v = ((rTbl[idx] + 65536) << 14) >> p;
    else begin
      idx = (idx & 510) | ((31 - p) & 1);
      v = ((sTbl[idx] + 65536) << 14) >> (p / 2);
    end
    if (x < 0) v = ~v;
    return v[31:0];
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; opValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    mPend = 0; mLatch = '0; mResHi = '0;
  endtask

  task automatic runOp(logic [2:0] op, logic [15:0] val, logic [2:0] sSel,
                       logic [2:0] dSel, string req, bit randVec);
    logic [127:0] vec;
    logic [15:0]  lane, exp;
    logic [31:0]  opnd, r;
    int pos;
    @(negedge clk);
    for (int w = 0; w < 4; w++) vec[w*32 +: 32] = randVec ? $urandom : 32'h0;
    pos = 7 - int'(sSel);
    vec[pos*16 +: 16] = val;
    lane = val;
    opValid = 1'b1; opCode = op; srcVec = vec; srcSel = sSel; dstSel = dSel;
    #2;
    if (op[1:0] == 2'b10) begin
      exp = mResHi;
      mPend = 1; mLatch = lane;
    end else begin
      opnd = (mPend && op[1:0] == 2'b01) ? {mLatch, lane} : {{16{lane[15]}}, lane};
      r = refCalc(opnd, op[2]);
      exp = r[15:0];
      mResHi = r[31:16];
      mPend = 0;
    end
    check("R2", longint'(dstValid), 1, "dstValid");
    check("R2", longint'(dstLane), longint'(7 - int'(dSel)), "dstLane");
    check(req, longint'(dstData), longint'(exp), "dstData");
  endtask

  task automatic idle(int n);
    for (int c = 0; c < n; c++) begin
      @(negedge clk);
      opValid = 1'b0; opCode = 3'($urandom);
      for (int w = 0; w < 4; w++) srcVec[w*32 +: 32] = $urandom;
      srcSel = 3'($urandom);
      #2;
      check("R10", longint'(dstValid), 0, "dstValid idle");
    end
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    longint a, b;
    rTbl[0] = 65535;
    for (int i = 1; i < 512; i++)
      rTbl[i] = ((((longint'(1) << 34) / (i + 512)) + 1) >> 8) & 65535;
    for (int i = 0; i < 512; i++) begin
      a = (i % 2 == 1) ? (i + 512) / 2 : i + 512;
      b = longint'($sqrt(17592186044416.0 / real'(a))) - 3;
      if (b < (longint'(1) << 17)) b = longint'(1) << 17;
      while (a * (b + 1) * (b + 1) < (longint'(1) << 44)) b++;
      sTbl[i] = (b >> 1) & 65535;
    end

    doReset();
    // R1: first high op returns zero stored half
    runOp(3'b010, 16'h1234, 3'd2, 3'd5, "R1", 1);
    doReset();
    // R1: low op right after reset is narrow (0x8000 -> special)
    runOp(3'b001, 16'h8000, 3'd0, 3'd0, "R1", 1);
    runOp(3'b010, 16'h0000, 3'd1, 3'd1, "R8", 0);
    // R4 saturations
    runOp(3'b000, 16'h0000, 3'd3, 3'd7, "R4", 1);
    runOp(3'b110, 16'h0000, 3'd3, 3'd2, "R4", 0);
    runOp(3'b100, 16'h0000, 3'd4, 3'd4, "R4", 1);
    runOp(3'b100, 16'h8000, 3'd6, 3'd6, "R4", 1);
    runOp(3'b010, 16'h0000, 3'd6, 3'd6, "R9", 0);
    // R5 and R6 single values
    runOp(3'b000, 16'h0001, 3'd7, 3'd0, "R5", 1);
    runOp(3'b000, 16'h7FFF, 3'd5, 3'd3, "R5", 1);
    runOp(3'b100, 16'h0001, 3'd0, 3'd1, "R6", 1);
    runOp(3'b100, 16'h0003, 3'd1, 3'd1, "R6", 1);
    // R7 negatives
    runOp(3'b000, 16'hFFFF, 3'd2, 3'd2, "R7", 1);
    runOp(3'b000, 16'h8001, 3'd2, 3'd2, "R7", 1);
    runOp(3'b100, 16'hFFFE, 3'd2, 3'd2, "R7", 1);
    // R3 wide pairs
    runOp(3'b010, 16'h0001, 3'd4, 3'd0, "R9", 1);
    runOp(3'b001, 16'h0000, 3'd4, 3'd0, "R3", 1);
    runOp(3'b110, 16'hFFFF, 3'd5, 3'd0, "R9", 1);
    runOp(3'b101, 16'h0000, 3'd5, 3'd0, "R3", 1);
    runOp(3'b010, 16'h8000, 3'd0, 3'd0, "R9", 1);
    runOp(3'b001, 16'h0000, 3'd0, 3'd0, "R7", 1);
    runOp(3'b010, 16'h1234, 3'd1, 3'd0, "R9", 1);
    runOp(3'b000, 16'h0005, 3'd1, 3'd0, "R3", 1);
    runOp(3'b001, 16'h0005, 3'd1, 3'd0, "R3", 1);
    runOp(3'b010, 16'h0042, 3'd3, 3'd0, "R9", 1);
    runOp(3'b011, 16'h0100, 3'd3, 3'd0, "R3", 1);
    runOp(3'b001, 16'h0100, 3'd3, 3'd0, "R3", 1);
    // R10 idle gap keeps latch and pending flag
    runOp(3'b010, 16'h4000, 3'd6, 3'd4, "R9", 1);
    idle(3);
    runOp(3'b001, 16'h0000, 3'd6, 3'd4, "R10", 1);
    idle(2);
    runOp(3'b110, 16'h0000, 3'd6, 3'd4, "R10", 1);
    // random mix
    for (int n = 0; n < 600; n++) begin
      logic [2:0] op;
      op = 3'($urandom);
      runOp(op, 16'($urandom), 3'($urandom), 3'($urandom),
            op[2] ? "R6" : "R5", 1);
      if ($urandom % 8 == 0) idle(1);
    end

    @(negedge clk);
    opValid = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule